// File: doc/BRIEF.md
# Serial-Programmed Clock Fanout Enable Controller

This block sits beside an 18-way clock fanout. A reference clock arrives on one pin and is copied to 18 outputs. Each copy can be stopped on its own, and a global output-enable pin can float all of them together. The per-output enable bits are loaded over a two-wire SMBus link. On that link the block is a slave that only accepts writes and cannot be read back.

A transfer begins with a start condition and the write address 0xD2. Next come two header bytes, which the block acknowledges and then discards. After them come data bytes. There is no register pointer, so the first data byte always lands in register 0, the next in register 1, and the next in register 2. The block acknowledges up to ten data bytes; bytes four to ten are thrown away. A new enable value is passed into the reference-clock domain and takes effect only while the reference is low, so no output ever emits a shortened pulse.

Top module: `clk_buf_ctrl`

## Requirements
- R1: After reset, all 18 clock outputs follow the reference clock, every tri-state control is high (driving), and the SDA pull-down is released.
- R2: Only the address byte 0xD2 is acknowledged. Any other address byte, including the read address 0xD3, is not acknowledged, and the remaining bytes of that transfer are neither acknowledged nor stored.
- R3: The two bytes after the address are acknowledged whatever their contents, and they never change an enable register.
- R4: Data bytes load registers 0, 1 and 2 in that order. The block's enable vector is {reg1[7:0], reg2[7:6], reg0[7:0]}, where bit k controls clk_o[k]. A register changes only at the end of its byte's acknowledge, which happens while SCL is low.
- R5: An output whose enable bit is 0 is held low. An output whose enable bit is 1 copies the reference clock.
- R6: Data bytes 4 to 10 are acknowledged and have no effect. The 11th and later data bytes are not acknowledged.
- R7: Register values persist across transfers. A write that carries only one data byte changes register 0 and leaves registers 1 and 2 as they were.
- R8: A start condition that arrives in the middle of a byte abandons that byte, and the next byte is treated as an address byte.
- R9: While oe_i is low, every bit of clk_oe_o is low, whatever the register contents. While oe_i is high, every bit is high.
- R10: While the reference clock stays high, no clock output changes value, even while a write is changing its enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock, faster than SCL |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| scl_i | input | 1 | SMBus clock line |
| sda_i | input | 1 | SMBus data line (wired level) |
| ref_clk_i | input | 1 | Reference clock to fan out |
| oe_i | input | 1 | Global output enable; low floats all outputs |
| sda_pull_o | output | 1 | Request to pull SDA low (acknowledge) |
| clk_o | output | 18 | Gated copies of the reference clock |
| clk_oe_o | output | 18 | Tri-state drive enable for each clock output |

## Verification
The hardest situation to reach is an enable bit changing while its output is running. A runt pulse could only appear in the short window where the updated bit crosses into the reference domain. To get there, the bench runs a burst of writes that toggle register 0 back and forth. In parallel, a monitor samples the outputs early and late in every high phase of the reference clock, which it runs at 10 MHz, and counts any high phase in which an output changed. Overlong transfers and a start that interrupts a byte after four bits are also driven, to reach the saturation and restart paths.

// File: rtl/clkbuf_pkg.sv
package clkbuf_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RX, ST_ACK, ST_WAIT} smb_st_e;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [1:0] scl_ff, sda_ff;
  logic       scl_q, sda_q;
  logic       scl_s, sda_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
      scl_q  <= scl_ff[1];
      sda_q  <= sda_ff[1];
    end
  end

  assign scl_s      = scl_ff[1];
  assign sda_s      = sda_ff[1];
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/smb_wr_slave.sv
module smb_wr_slave
  import clkbuf_pkg::*;
#(
  parameter logic [7:0]  DEV_ADDR = 8'hD2,
  parameter int          N_HDR    = 2,
  parameter int          MAX_DATA = 10,
  parameter int          N_REGS   = 3,
  parameter logic [N_REGS*8-1:0] RST_VAL = 24'hC0FFFF
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sda_i,
  input  logic                scl_rise_i,
  input  logic                scl_fall_i,
  input  logic                start_i,
  input  logic                stop_i,
  output logic                sda_pull_o,
  output logic [N_REGS*8-1:0] regs_o
);
  localparam int IDX_MAX = N_HDR + MAX_DATA + 1;
  localparam int IDXW    = $clog2(IDX_MAX + 1);
  localparam logic [IDXW-1:0] LAST_ACK = IDXW'(N_HDR + MAX_DATA);
  localparam logic [IDXW-1:0] IDX_SAT  = IDXW'(IDX_MAX);

  smb_st_e         st;
  logic [2:0]      bit_cnt;
  logic            byte_done;
  logic [7:0]      shreg;
  logic [IDXW-1:0] idx;
  logic            ack_ok;
  logic            commit;

  assign ack_ok = (idx == '0) ? (shreg == DEV_ADDR) : (idx <= LAST_ACK);
  assign commit = (st == ST_ACK) && scl_fall_i && !start_i && !stop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st         <= ST_IDLE;
      bit_cnt    <= '0;
      byte_done  <= 1'b0;
      shreg      <= '0;
      idx        <= '0;
      sda_pull_o <= 1'b0;
    end else if (start_i) begin
      st         <= ST_RX;
      bit_cnt    <= '0;
      byte_done  <= 1'b0;
      idx        <= '0;
      sda_pull_o <= 1'b0;
    end else if (stop_i) begin
      st         <= ST_IDLE;
      byte_done  <= 1'b0;
      sda_pull_o <= 1'b0;
    end else begin
      unique case (st)
        ST_RX: begin
          if (scl_rise_i && !byte_done) begin
            shreg   <= {shreg[6:0], sda_i};
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) byte_done <= 1'b1;
          end else if (scl_fall_i && byte_done) begin
            byte_done <= 1'b0;
            if (ack_ok) begin
              sda_pull_o <= 1'b1;
              st         <= ST_ACK;
            end else begin
              st <= ST_WAIT;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall_i) begin
            sda_pull_o <= 1'b0;
            bit_cnt    <= '0;
            st         <= ST_RX;
            if (idx != IDX_SAT) idx <= idx + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // one register per data slot; slot k is written when byte index N_HDR+1+k is acked
  for (genvar k = 0; k < N_REGS; k++) begin : g_reg
    localparam logic [IDXW-1:0] SLOT = IDXW'(N_HDR + 1 + k);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    regs_o[k*8 +: 8] <= RST_VAL[k*8 +: 8];
      else if (commit && idx == SLOT) regs_o[k*8 +: 8] <= shreg;
    end
  end
endmodule

// File: rtl/clk_gate_bank.sv
module clk_gate_bank #(
  parameter int N_OUT = 18
) (
  input  logic             ref_clk_i,
  input  logic             rst_ni,
  input  logic             oe_i,
  input  logic [N_OUT-1:0] en_i,
  output logic [N_OUT-1:0] clk_o,
  output logic [N_OUT-1:0] clk_oe_o
);
  for (genvar g = 0; g < N_OUT; g++) begin : g_out
    logic en_m, en_s;
    // retimed on the falling edge so the gate only moves while the reference is low
    always_ff @(negedge ref_clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_m <= 1'b1;
        en_s <= 1'b1;
      end else begin
        en_m <= en_i[g];
        en_s <= en_m;
      end
    end
    assign clk_o[g]    = ref_clk_i & en_s;
    assign clk_oe_o[g] = oe_i;
  end
endmodule

// File: rtl/clk_buf_ctrl.sv
module clk_buf_ctrl #(
  parameter logic [7:0] DEV_ADDR = 8'hD2,
  parameter int         MAX_DATA = 10
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        scl_i,
  input  logic        sda_i,
  input  logic        ref_clk_i,
  input  logic        oe_i,
  output logic        sda_pull_o,
  output logic [17:0] clk_o,
  output logic [17:0] clk_oe_o
);
  localparam int N_OUT  = 18;
  localparam int N_REGS = 3;
  localparam int N_HDR  = 2;

  logic sda_s, scl_rise, scl_fall, start_c, stop_c;
  logic [N_REGS*8-1:0] regs;
  logic [N_OUT-1:0]    en_vec;
  logic [5:0]          unused_r2;

  smb_line_sync u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_o     (sda_s),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_c),
    .stop_o    (stop_c)
  );

  smb_wr_slave #(
    .DEV_ADDR(DEV_ADDR),
    .N_HDR   (N_HDR),
    .MAX_DATA(MAX_DATA),
    .N_REGS  (N_REGS),
    .RST_VAL (24'hC0FFFF)
  ) u_slave (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sda_i     (sda_s),
    .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall),
    .start_i   (start_c),
    .stop_i    (stop_c),
    .sda_pull_o(sda_pull_o),
    .regs_o    (regs)
  );

  // reg0 -> outputs 0..7, reg2[7:6] -> outputs 9..8, reg1 -> outputs 17..10
  assign en_vec    = {regs[15:8], regs[23:22], regs[7:0]};
  assign unused_r2 = regs[21:16];

  clk_gate_bank #(.N_OUT(N_OUT)) u_gate (
    .ref_clk_i(ref_clk_i),
    .rst_ni   (rst_ni),
    .oe_i     (oe_i),
    .en_i     (en_vec),
    .clk_o    (clk_o),
    .clk_oe_o (clk_oe_o)
  );
endmodule

// File: rtl/clk_buf_ctrl_chk.sv
module clk_buf_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        scl_i,
  input logic        oe_i,
  input logic        ref_clk_i,
  input logic        sda_pull_o,
  input logic [17:0] clk_o,
  input logic [17:0] clk_oe_o,
  input logic [17:0] en_vec
);
  // R9
  oe_low_float_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |-> clk_oe_o == 18'h0);
  // R9
  oe_high_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_i |-> &clk_oe_o);
  // R10
  no_runt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_clk_i && $past(ref_clk_i)) |-> clk_o == $past(clk_o));
  // R2
  ack_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_pull_o) |-> !scl_i);
  // R4
  reg_upd_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(en_vec) |-> !scl_i);
endmodule

bind clk_buf_ctrl clk_buf_ctrl_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .scl_i     (scl_i),
  .oe_i      (oe_i),
  .ref_clk_i (ref_clk_i),
  .sda_pull_o(sda_pull_o),
  .clk_o     (clk_o),
  .clk_oe_o  (clk_oe_o),
  .en_vec    (en_vec)
);

// File: tb/clk_buf_ctrl_bench.sv
`timescale 1ns/1ps
module clk_buf_ctrl_bench;
  localparam int Q = 100;

  logic clk = 1'b0, rst_ni = 1'b0, ref_clk = 1'b0, oe = 1'b1;
  logic scl = 1'b1, sda_drv = 1'b1;
  logic sda_pull;
  logic [17:0] clk_o, clk_oe;
  wire  sda_line = sda_drv & ~sda_pull;

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  logic [7:0] r0 = 8'hFF, r1 = 8'hFF, r2 = 8'hC0;
  logic [7:0] dbuf [16];

  always #10 clk = ~clk;
  always #50 ref_clk = ~ref_clk;

  clk_buf_ctrl u_clk_buf_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl), .sda_i(sda_line),
    .ref_clk_i(ref_clk), .oe_i(oe), .sda_pull_o(sda_pull),
    .clk_o(clk_o), .clk_oe_o(clk_oe)
  );

  function automatic logic [17:0] exp_en();
    return {r1, r2[7:6], r0};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; #Q; scl = 1'b1; #Q; sda_drv = 1'b0; #Q; scl = 1'b0; #Q;
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; #Q; scl = 1'b1; #Q; sda_drv = 1'b1; #Q;
  endtask

  task automatic send_bit(input logic b);
    sda_drv = b; #Q; scl = 1'b1; #(2*Q); scl = 1'b0; #Q;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_drv = 1'b1; #Q; scl = 1'b1; #Q;
    ack = (sda_line == 1'b0);
    #Q; scl = 1'b0; #Q;
  endtask

  // address, two header bytes, then n data bytes from dbuf
  task automatic write_block(input logic [7:0] cmd, input logic [7:0] cnt, input int n, input string req);
    bit a;
    bus_start();
    send_byte(8'hD2, a); chk(a, "R2", 32'(a), 1);
    send_byte(cmd, a);   chk(a, "R3", 32'(a), 1);
    send_byte(cnt, a);   chk(a, "R3", 32'(a), 1);
    for (int i = 0; i < n; i++) begin
      send_byte(dbuf[i], a);
      chk(a == (i < 10), req, 32'(a), 32'(i < 10));
      if (i == 0) r0 = dbuf[i];
      if (i == 1) r1 = dbuf[i];
      if (i == 2) r2 = dbuf[i];
    end
    bus_stop();
  endtask

  task automatic check_outs(input string req);
    repeat (3) @(negedge ref_clk);
    @(posedge ref_clk); #20;
    chk(clk_o == exp_en(), req, 32'(clk_o), 32'(exp_en()));
    chk(clk_oe == 18'h3FFFF, req, 32'(clk_oe), 32'h3FFFF);
    @(negedge ref_clk); #20;
    chk(clk_o == 18'h0, req, 32'(clk_o), 0);
  endtask

  task automatic t_reset();
    chk(sda_pull == 1'b0, "R1", 32'(sda_pull), 0);
    check_outs("R1");
  endtask

  task automatic t_full_write();
    dbuf[0] = 8'h0F; dbuf[1] = 8'hF0; dbuf[2] = 8'h40;
    write_block(8'h55, 8'hAA, 3, "R4");
    check_outs("R4");
    chk(exp_en() == 18'h3C10F, "R5", 32'(exp_en()), 32'h3C10F);
  endtask

  task automatic t_partial();
    dbuf[0] = 8'hA5;
    write_block(8'h00, 8'h01, 1, "R7");
    check_outs("R7");
  endtask

  task automatic t_bad_addr();
    bit a;
    bus_start();
    send_byte(8'hD0, a); chk(!a, "R2", 32'(a), 0);
    send_byte(8'h00, a); chk(!a, "R2", 32'(a), 0);
    send_byte(8'h00, a); chk(!a, "R2", 32'(a), 0);
    send_byte(8'h00, a); chk(!a, "R2", 32'(a), 0);
    bus_stop();
    bus_start();
    send_byte(8'hD3, a); chk(!a, "R2", 32'(a), 0);
    send_byte(8'h00, a); chk(!a, "R2", 32'(a), 0);
    bus_stop();
    check_outs("R2");
  endtask

  task automatic t_overlong();
    dbuf[0] = 8'h33; dbuf[1] = 8'hCC; dbuf[2] = 8'h80;
    for (int i = 3; i < 12; i++) dbuf[i] = 8'h00;
    write_block(8'hFF, 8'hFF, 12, "R6");
    check_outs("R6");
  endtask

  task automatic t_restart();
    bit a;
    bus_start();
    send_byte(8'hD2, a); chk(a, "R8", 32'(a), 1);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    dbuf[0] = 8'h5A;
    write_block(8'h12, 8'h34, 1, "R8");
    check_outs("R8");
  endtask

  task automatic t_oe();
    oe = 1'b0; #50;
    chk(clk_oe == 18'h0, "R9", 32'(clk_oe), 0);
    @(posedge ref_clk); #20;
    chk(clk_oe == 18'h0, "R9", 32'(clk_oe), 0);
    oe = 1'b1; #50;
    chk(clk_oe == 18'h3FFFF, "R9", 32'(clk_oe), 32'h3FFFF);
  endtask

  task automatic t_glitch();
    bit done = 1'b0;
    int bad = 0;
    fork
      begin
        for (int k = 0; k < 4; k++) begin
          dbuf[0] = (k % 2 == 0) ? 8'h00 : 8'hFF;
          write_block(8'h00, 8'h01, 1, "R10");
        end
        done = 1'b1;
      end
      begin
        logic [17:0] a0, a1;
        while (!done) begin
          @(posedge ref_clk); #2; a0 = clk_o; #40; a1 = clk_o;
          if (a0 != a1) bad++;
        end
      end
    join
    chk(bad == 0, "R10", 32'(bad), 0);
    check_outs("R10");
  endtask

  initial begin
    #(2_000_000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    #3 rst_ni = 1'b1;
    repeat (5) @(posedge clk);
    t_reset();
    t_full_write();
    t_partial();
    t_bad_addr();
    t_overlong();
    t_restart();
    t_oe();
    t_glitch();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule